// File: doc/BRIEF.md
# Trigger-Started Synchronous Full-Duplex Serial Port

This block is a clock-synchronous serial transceiver that moves one 8-bit byte out and one 8-bit byte in at the same time. It never generates a baud rate of its own. The serial clock comes from a free-running external source. The port stays quiet until software has armed it and a falling edge then appears on a dedicated trigger pin. From that point it derives a bit clock from the external clock, either passing it straight through or dividing it by two, and shifts bits least significant first.

Software controls the port through level configuration inputs, a transmit write strobe, a receive read strobe and a run-clear strobe. Hardware sets the run flag when it accepts a trigger. A transmit interrupt pulse fires either when a byte leaves the holding buffer or when its last bit has been sent, and a receive interrupt pulse fires when a byte lands in the receive buffer. If the receive buffer has not been read by the time the seventh bit of the next byte has been sampled, the port flags an overrun. That frame then raises no receive interrupt and does not update the buffer.

Top module: `trig_sync_serial`

## Requirements
- R1: A frame has 8 data bits, shifted least significant bit first. txd changes after each falling bit-clock edge, and rxd is sampled on each rising bit-clock edge of the same frame.
- R2: With cfg_div2=0 the bit clock equals ext_sclk. With cfg_div2=1 it runs at half rate: the accepted trigger resets the divider phase, so the first ext_sclk rising edge after the trigger is a sampling edge and the following rising edge is a shifting edge.
- R3: A trigger is accepted only when cfg_te=1, cfg_re=1, tx_full=1, run=0 and the synchronized trig_n shows a high-to-low transition.
- R4: An accepted trigger sets run to 1, moves the holding buffer into the transmit shift register and clears tx_full.
- R5: A run_clr pulse makes run 0 on the next cycle and abandons the frame in progress: txd returns high and no later bit clock edges update rx_full or rx_data.
- R6: With cfg_irq_sel=0, tx_irq pulses for one cycle when the holding buffer moves into the shift register. With cfg_irq_sel=1, it pulses when the 8th falling bit-clock edge of the frame ends the last bit.
- R7: On the 8th rising bit-clock edge, the received byte moves into rx_data, rx_full is set and rx_irq pulses for one cycle.
- R8: If rx_full is still 1 at the 7th rising bit-clock edge of a frame, ovr is set. At the end of that frame, rx_irq does not pulse and rx_data keeps its previous value.
- R9: A trigger edge while run=1, or while any arming condition is missing, is ignored: run, tx_full and tx_irq are unaffected.
- R10: txd is 1 whenever no frame is shifting, including after reset and after a frame that ends without a further byte.
- R11: If tx_full=1 when a frame ends and run is still 1, the next frame starts at once from the holding buffer without a new trigger.
- R12: An rx_rd pulse clears rx_full and ovr.
- R13: After reset, run, tx_full, rx_full and ovr are 0 and txd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sclk | input | 1 | Free-running external serial clock |
| trig_n | input | 1 | Trigger pin; a falling edge starts a transfer |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data, idles high |
| cfg_te | input | 1 | Transmit enable |
| cfg_re | input | 1 | Receive enable |
| cfg_div2 | input | 1 | 1 selects bit clock = ext_sclk / 2 |
| cfg_irq_sel | input | 1 | Transmit interrupt timing select |
| tx_wr | input | 1 | Write strobe for the holding buffer |
| tx_data | input | 8 | Byte to write into the holding buffer |
| tx_full | output | 1 | Holding buffer holds a byte |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| ovr | output | 1 | Overrun flag |
| run_clr | input | 1 | Software pulse that clears the run flag |
| run | output | 1 | Run flag, set by an accepted trigger |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
On every cycle the assertions check that run rises only under the full set of arming conditions, that no load happens while running except at a frame boundary, that txd idles high without run, that the two interrupt timings follow the select bit, and that the overrun flag and the suppressed receive interrupt follow the 7th and 8th sampling edges. Only the bench scenarios can show that the bits reach the pins in the right order at the right bit-clock phase in both divide settings, that back-to-back frames chain without a trigger, and that a stopped frame leaves the receive buffer untouched while ext_sclk keeps running.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int unsigned FRAME_BITS = 8;

  // Sampling (rising) bit-clock event derived from an external rising edge.
  function automatic logic div_rise(input logic div2, input logic phase,
                                    input logic ext_rise);
    return ext_rise & (~div2 | ~phase);
  endfunction

  // Shifting (falling) bit-clock event.
  function automatic logic div_fall(input logic div2, input logic phase,
                                    input logic ext_rise, input logic ext_fall);
    return div2 ? (ext_rise & phase) : ext_fall;
  endfunction

  // Overrun hit: 7th sample with an unread buffer not being read now.
  function automatic logic ovr_hit(input logic near, input logic full,
                                   input logic rd);
    return near & full & ~rd;
  endfunction
endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= st[s-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tss_bitclk.sv
module tss_bitclk (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic div2,
  input  logic restart,
  output logic bit_rise,
  output logic bit_fall
);
  import tss_pkg::*;

  logic sclk_d;
  logic phase;
  logic ext_rise;
  logic ext_fall;

  assign ext_rise = sclk_s & ~sclk_d;
  assign ext_fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      phase  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (restart)               phase <= 1'b0;
      else if (div2 && ext_rise) phase <= ~phase;
    end
  end

  assign bit_rise = div_rise(div2, phase, ext_rise);
  assign bit_fall = div_fall(div2, phase, ext_rise, ext_fall);
endmodule

// File: rtl/tss_shift.sv
module tss_shift #(
  parameter int unsigned DATA_W = tss_pkg::FRAME_BITS,
  localparam int unsigned CW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              stop,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              rxd,
  output logic              txd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_done,
  output logic              rx_near,
  output logic              frame_end
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-2:0] rx_sr;
  logic [CW-1:0]     cnt;
  logic              hi;
  logic              active;

  assign rx_byte   = {rxd, rx_sr};
  assign rx_done   = active & bit_rise & (cnt == CW'(DATA_W - 1));
  assign rx_near   = active & bit_rise & (cnt == CW'(DATA_W - 2));
  assign frame_end = active & bit_fall & hi & (cnt == CW'(DATA_W));
  assign txd       = active ? tx_sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '1;
      rx_sr  <= '0;
      cnt    <= '0;
      hi     <= 1'b0;
      active <= 1'b0;
    end else if (stop) begin
      hi     <= 1'b0;
      active <= 1'b0;
    end else if (load) begin
      tx_sr  <= load_data;
      cnt    <= '0;
      hi     <= 1'b0;
      active <= 1'b1;
    end else if (active) begin
      if (bit_rise && cnt < CW'(DATA_W)) begin
        rx_sr <= rx_byte[DATA_W-1:1];
        cnt   <= cnt + 1'b1;
        hi    <= 1'b1;
      end else if (bit_fall && hi) begin
        hi    <= 1'b0;
        tx_sr <= {1'b1, tx_sr[DATA_W-1:1]};
        if (cnt == CW'(DATA_W)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trig_sync_serial.sv
module trig_sync_serial #(
  parameter int unsigned DATA_W = tss_pkg::FRAME_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sclk,
  input  logic              trig_n,
  input  logic              rxd,
  output logic              txd,
  input  logic              cfg_te,
  input  logic              cfg_re,
  input  logic              cfg_div2,
  input  logic              cfg_irq_sel,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr,
  input  logic              run_clr,
  output logic              run,
  output logic              tx_irq,
  output logic              rx_irq
);
  import tss_pkg::*;

  logic [2:0]        sync_q;
  logic              sclk_s, trig_s, rxd_s, trig_d;
  logic              trig_fall_w, accept_w, reload_w, load_w;
  logic              bit_rise, bit_fall;
  logic              rx_done_w, rx_near_w, frame_end_w;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] tx_buf;
  logic              ovr_frame_w;

  tss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_sclk, trig_n, rxd}), .q(sync_q)
  );
  assign {sclk_s, trig_s, rxd_s} = sync_q;

  assign trig_fall_w = trig_d & ~trig_s;
  assign accept_w    = trig_fall_w & cfg_te & cfg_re & tx_full & ~run & ~run_clr;
  assign reload_w    = frame_end_w & tx_full & run & ~run_clr;
  assign load_w      = accept_w | reload_w;

  tss_bitclk u_bitclk (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .div2(cfg_div2),
    .restart(accept_w), .bit_rise(bit_rise), .bit_fall(bit_fall)
  );

  tss_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_w), .load_data(tx_buf),
    .stop(run_clr), .bit_rise(bit_rise), .bit_fall(bit_fall), .rxd(rxd_s),
    .txd(txd), .rx_byte(rx_byte), .rx_done(rx_done_w), .rx_near(rx_near_w),
    .frame_end(frame_end_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_d      <= 1'b1;
      run         <= 1'b0;
      tx_buf      <= '0;
      tx_full     <= 1'b0;
      rx_data     <= '0;
      rx_full     <= 1'b0;
      ovr         <= 1'b0;
      ovr_frame_w <= 1'b0;
      tx_irq      <= 1'b0;
      rx_irq      <= 1'b0;
    end else begin
      trig_d <= trig_s;

      if (run_clr)       run <= 1'b0;
      else if (accept_w) run <= 1'b1;

      if (load_w) tx_full <= 1'b0;
      if (tx_wr) begin
        tx_buf  <= tx_data;
        tx_full <= 1'b1;
      end

      if (rx_rd) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
      end
      if (ovr_hit(rx_near_w, rx_full, rx_rd)) ovr <= 1'b1;

      if (rx_done_w && !ovr_frame_w) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end

      if (rx_done_w || run_clr)                    ovr_frame_w <= 1'b0;
      else if (ovr_hit(rx_near_w, rx_full, rx_rd)) ovr_frame_w <= 1'b1;

      tx_irq <= (load_w & ~cfg_irq_sel) | (frame_end_w & cfg_irq_sel);
      rx_irq <= rx_done_w & ~ovr_frame_w;
    end
  end
endmodule

// File: rtl/tss_checker.sv
module tss_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_te,
  input logic cfg_re,
  input logic cfg_irq_sel,
  input logic tx_wr,
  input logic tx_full,
  input logic run,
  input logic run_clr,
  input logic txd,
  input logic rx_full,
  input logic rx_rd,
  input logic ovr,
  input logic tx_irq,
  input logic rx_irq,
  input logic trig_fall_w,
  input logic accept_w,
  input logic load_w,
  input logic frame_end_w,
  input logic rx_done_w,
  input logic rx_near_w,
  input logic ovr_frame_w
);
  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(cfg_te && cfg_re && tx_full && trig_fall_w));

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !tx_wr |=> run && !tx_full);

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |=> !run && txd);

  p_txirq_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_w && !cfg_irq_sel |=> tx_irq);

  p_txirq_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_w && cfg_irq_sel |=> tx_irq);

  p_rxfull_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_done_w && !ovr_frame_w));

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_near_w && rx_full && !rx_rd |=> ovr);

  p_no_rxirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_w && ovr_frame_w |=> !rx_irq);

  p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run && !frame_end_w |-> !load_w);

  p_idle_txd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> txd);

  p_rd_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_done_w |=> !rx_full);

  p_rd_ovr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_near_w |=> !ovr);
endmodule

bind trig_sync_serial tss_checker u_tss_checker (
  .clk(clk), .rst_n(rst_n), .cfg_te(cfg_te), .cfg_re(cfg_re),
  .cfg_irq_sel(cfg_irq_sel), .tx_wr(tx_wr), .tx_full(tx_full), .run(run),
  .run_clr(run_clr), .txd(txd), .rx_full(rx_full), .rx_rd(rx_rd), .ovr(ovr),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .trig_fall_w(trig_fall_w),
  .accept_w(accept_w), .load_w(load_w), .frame_end_w(frame_end_w),
  .rx_done_w(rx_done_w), .rx_near_w(rx_near_w), .ovr_frame_w(ovr_frame_w)
);

// File: tb/trig_sync_serial_bench.sv
module trig_sync_serial_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, ext_sclk, trig_n, rxd, txd;
  logic       cfg_te, cfg_re, cfg_div2, cfg_irq_sel;
  logic       tx_wr, tx_full, rx_rd, rx_full, ovr, run_clr, run, tx_irq, rx_irq;
  logic [7:0] tx_data, rx_data;

  trig_sync_serial u_trig_sync_serial (
    .clk(clk), .rst_n(rst_n), .ext_sclk(ext_sclk), .trig_n(trig_n), .rxd(rxd),
    .txd(txd), .cfg_te(cfg_te), .cfg_re(cfg_re), .cfg_div2(cfg_div2),
    .cfg_irq_sel(cfg_irq_sel), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .ovr(ovr), .run_clr(run_clr), .run(run), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // {div2, tx byte, rx byte}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 8'hA5, 8'h3C}, {1'b1, 8'h81, 8'h7E},
    {1'b0, 8'h00, 8'hFF}, {1'b1, 8'hFF, 8'h01}
  };

  int n_chk = 0, n_bad = 0, n_txirq = 0, n_rxirq = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (tx_irq) n_txirq++;
    if (rx_irq) n_rxirq++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk); run_clr = 1'b1;
    @(negedge clk); run_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic trigger();
    @(negedge clk); trig_n = 1'b0;
    repeat (4) @(negedge clk);
    trig_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Drives ncyc external clock periods; d = bit-clock divide factor.
  task automatic frame(input int d, input logic [7:0] rxb, input int ncyc,
                       output logic [7:0] cap);
    cap = 8'h00;
    for (int c = 0; c < ncyc; c++) begin
      if (c % d == 0) rxd = rxb[c / d];
      repeat (5) @(negedge clk);
      if (c % d == 0) cap[c / d] = txd;
      ext_sclk = 1'b1;
      repeat (6) @(negedge clk);
      ext_sclk = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    int t0, r0;
    rst_n = 1'b0; ext_sclk = 1'b0; trig_n = 1'b1; rxd = 1'b1;
    cfg_te = 1'b1; cfg_re = 1'b1; cfg_div2 = 1'b0; cfg_irq_sel = 1'b0;
    tx_wr = 1'b0; tx_data = '0; rx_rd = 1'b0; run_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset run", run, 0);
    chk("R13 reset tx_full", tx_full, 0);
    chk("R13 reset rx_full", rx_full, 0);
    chk("R13 reset ovr", ovr, 0);
    chk("R10 reset txd", txd, 1);

    // Vector table: one frame per entry.
    for (int i = 0; i < 4; i++) begin
      cfg_div2 = VEC[i][16];
      wr_tx(VEC[i][15:8]);
      t0 = n_txirq; r0 = n_rxirq;
      trigger();
      chk("R4 run set", run, 1);
      chk("R4 tx_full cleared", tx_full, 0);
      frame(VEC[i][16] ? 2 : 1, VEC[i][7:0], VEC[i][16] ? 16 : 8, cap);
      chk(VEC[i][16] ? "R2 div2 tx bits" : "R1 tx bits lsb first", cap, VEC[i][15:8]);
      chk(VEC[i][16] ? "R2 div2 rx byte" : "R1 rx byte", rx_data, VEC[i][7:0]);
      chk("R7 rx_full", rx_full, 1);
      chk("R7 rx_irq count", n_rxirq - r0, 1);
      chk("R6 tx_irq at load", n_txirq - t0, 1);
      chk("R10 txd idle after frame", txd, 1);
      rd_rx();
      chk("R12 rx_full cleared", rx_full, 0);
      stop_run();
      chk("R5 run cleared", run, 0);
    end

    // Not armed: transmit disabled.
    cfg_div2 = 1'b0;
    cfg_te = 1'b0;
    wr_tx(8'h33);
    t0 = n_txirq;
    trigger();
    chk("R9 unarmed run", run, 0);
    chk("R9 unarmed tx_full", tx_full, 1);
    chk("R3 unarmed no tx_irq", n_txirq - t0, 0);
    cfg_te = 1'b1;
    trigger();
    chk("R3 armed accept", run, 1);

    // Trigger while running is ignored; chained frames with overrun.
    wr_tx(8'h44);
    t0 = n_txirq; r0 = n_rxirq;
    trigger();
    chk("R9 busy keeps tx_full", tx_full, 1);
    chk("R9 busy no tx_irq", n_txirq - t0, 0);
    frame(1, 8'h11, 8, cap);
    chk("R1 chain first tx", cap, 8'h33);
    chk("R11 reload cleared tx_full", tx_full, 0);
    frame(1, 8'h22, 8, cap);
    chk("R11 chained second tx", cap, 8'h44);
    chk("R8 ovr set", ovr, 1);
    chk("R8 rx_irq suppressed", n_rxirq - r0, 1);
    chk("R8 rx_data kept", rx_data, 8'h11);
    rd_rx();
    chk("R12 ovr cleared", ovr, 0);
    chk("R12 rx_full cleared after ovr", rx_full, 0);
    stop_run();

    // Transmit interrupt at end of last bit.
    cfg_irq_sel = 1'b1;
    wr_tx(8'h96);
    t0 = n_txirq;
    trigger();
    chk("R6 sel1 no irq at load", n_txirq - t0, 0);
    frame(1, 8'h5A, 8, cap);
    chk("R6 sel1 irq at end", n_txirq - t0, 1);
    chk("R1 sel1 tx bits", cap, 8'h96);
    rd_rx();
    stop_run();
    cfg_irq_sel = 1'b0;

    // Stop partway through a frame.
    wr_tx(8'h5A);
    r0 = n_rxirq;
    trigger();
    frame(1, 8'hC3, 3, cap);
    stop_run();
    chk("R5 run after stop", run, 0);
    chk("R5 txd after stop", txd, 1);
    frame(1, 8'hC3, 8, cap);
    chk("R5 no rx after stop", rx_full, 0);
    chk("R5 no rx_irq after stop", n_rxirq - r0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule